// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a software-serviced watchdog with two levels of escalation. Software programs a timeout value and turns the block on. From then on, a down-counter loses one step on every pulse of a one-microsecond tick input. The tick comes from a prescaler outside the block.

When the count is already zero and one more tick arrives, the timer expires. The first expiry raises a level interrupt and reloads the counter from the programmed value, which gives software one more full period to respond. If a second expiry follows without a kick, the block emits a one-cycle chip-reset request. No mask, enable or routing option can suppress that request.

Software talks to the block through a small write-only register port. There are three addresses: one stores the timeout value, one sets the enable, and one kicks (services) the timer. Every port is a plain control or status pin. No data stream crosses the block boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `wdog_twostage`

## Requirements
- R1: After reset, `irq` and `rst_req` are 0, the block is disabled, and the counter and the stored timeout are 0.
- R2: While enabled, the counter decreases by exactly one on each clock cycle in which `tick_us` is 1, and it does not change on cycles without a tick.
- R3: The timer expires on the tick that arrives while the count is 0. A timeout value V written at address 0 therefore gives an expiry on the (V+1)-th tick after the write or after a kick.
- R4: At the first expiry, `irq` goes to 1 and stays at 1, the counter reloads from the stored timeout, and `rst_req` stays at 0.
- R5: An expiry that occurs while the first expiry is still unserviced drives `rst_req` to 1 for exactly one clock cycle, and `irq` remains 1. No configuration can suppress this pulse.
- R6: A write to address 2 (kick; the data is ignored) reloads the counter from the stored timeout, clears `irq` and clears the first-expiry record. A tick in the same cycle as the kick does not count and does not cause an expiry.
- R7: A write to address 1 with data bit 0 = 0 disables the block, and `irq` and the first-expiry record are cleared at that same edge. While disabled, the counter holds, ticks are ignored, and neither `irq` nor `rst_req` is asserted. A write to address 1 with bit 0 = 1 re-enables the block, and counting resumes from the held value.
- R8: A write to address 0 stores `cfg_wdata` as the timeout and loads it into the counter at the same edge. It leaves `irq` and the first-expiry record unchanged.
- R9: A timeout value of all ones (2^CNT_W − 1, which is 0x7FFFFF at the default width of 23) gives a period of 2^CNT_W ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse, once per microsecond |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | 0 = timeout value, 1 = enable (bit 0), 2 = kick, 3 = unused |
| cfg_wdata | input | CNT_W | Write data |
| irq | output | 1 | First-expiry interrupt, a level held until a kick or a disable |
| rst_req | output | 1 | Chip-reset request, a single-cycle pulse |

## Verification
Register writes, ticks and expiries all take effect at the edge where they are sampled. So `irq` and `rst_req` change one edge after the tick, kick or disable that causes them. A write to address 0 is in effect at the edge that samples it. The bench drives every input on the falling clock edge and samples the outputs on the next falling edge, which is half a cycle after the edge that updates them. A free-running counter counts how many cycles `rst_req` is high, which is how the bench confirms that the reset request is a single-cycle pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_REG_TIMEOUT = 2'd0,
    WD_REG_ENABLE  = 2'd1,
    WD_REG_KICK    = 2'd2
  } wd_reg_e;
endpackage

// File: rtl/wdog_cfg_regs.sv
module wdog_cfg_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0] reload_val,
  output logic             en,
  output logic             load_stb,
  output logic             kick_stb,
  output logic             dis_stb
);
  logic en_stb;

  always_comb begin
    load_stb = cfg_wr && (cfg_addr == WD_REG_TIMEOUT);
    en_stb   = cfg_wr && (cfg_addr == WD_REG_ENABLE);
    kick_stb = cfg_wr && (cfg_addr == WD_REG_KICK);
    dis_stb  = en_stb && !cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_val <= '0;
      en         <= 1'b0;
    end else begin
      if (load_stb) reload_val <= cfg_wdata;
      if (en_stb)   en         <= cfg_wdata[0];
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_data,
  input  logic             kick_stb,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic at_zero;

  assign at_zero = (cnt == '0);
  // a tick at zero expires unless a write reloads the counter this cycle
  assign expire  = en && tick && at_zero && !load_stb && !kick_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load_stb) begin
      cnt <= load_data;
    end else if (kick_stb || expire) begin
      cnt <= reload_val;
    end else if (en && tick) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_stage_ctrl.sv
module wdog_stage_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dis_stb,
  input  logic kick_stb,
  input  logic expire,
  output logic irq,
  output logic rst_req,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
      armed   <= 1'b0;
    end else if (!en || dis_stb || kick_stb) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
      armed   <= 1'b0;
    end else if (expire) begin
      if (armed) begin
        rst_req <= 1'b1;
        armed   <= 1'b0;
      end else begin
        irq     <= 1'b1;
        armed   <= 1'b1;
        rst_req <= 1'b0;
      end
    end else begin
      rst_req <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic             irq,
  output logic             rst_req
);
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cnt;
  logic             en;
  logic             load_stb;
  logic             kick_stb;
  logic             dis_stb;
  logic             expire;
  logic             armed;

  wdog_cfg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .reload_val(reload_val), .en(en),
    .load_stb(load_stb), .kick_stb(kick_stb), .dis_stb(dis_stb)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .en(en),
    .load_stb(load_stb), .load_data(cfg_wdata), .kick_stb(kick_stb),
    .reload_val(reload_val), .cnt(cnt), .expire(expire)
  );

  wdog_stage_ctrl u_stage (
    .clk(clk), .rst_n(rst_n), .en(en), .dis_stb(dis_stb),
    .kick_stb(kick_stb), .expire(expire), .irq(irq),
    .rst_req(rst_req), .armed(armed)
  );
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
  parameter int CNT_W = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_us,
  input logic             cfg_wr,
  input logic [1:0]       cfg_addr,
  input logic [CNT_W-1:0] cfg_wdata,
  input logic             irq,
  input logic             rst_req,
  input logic             en,
  input logic             armed,
  input logic [CNT_W-1:0] cnt
);
  p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_rst_with_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> irq);

  p_kick_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 2'd2) |=> (!irq && !armed && !rst_req));

  p_dis_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!irq && !rst_req && !armed));

  p_dis_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cfg_wr) |=> $stable(cnt));

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick_us && cnt != '0 && !cfg_wr) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_us && !cfg_wr) |=> $stable(cnt));

  p_first_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick_us && cnt == '0 && !cfg_wr && !armed) |=> (irq && !rst_req && armed));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 2'd0) |=> (cnt == $past(cfg_wdata)));
endmodule

bind wdog_twostage wdog_twostage_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cfg_wr(cfg_wr),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq(irq),
  .rst_req(rst_req), .en(en), .armed(armed), .cnt(cnt)
);

// File: tb/tb_wdog_twostage.sv
module tb_wdog_twostage;
  localparam int W  = 23;
  localparam int WN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [W-1:0] cfg_wdata = '0;
  logic irq, rst_req, irq_n, rst_req_n;

  int errors = 0;
  int checks = 0;
  int rst_cycles = 0;

  always #2 clk = ~clk;

  wdog_twostage #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq(irq), .rst_req(rst_req)
  );

  wdog_twostage #(.CNT_W(WN)) dut_narrow (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata[WN-1:0]), .irq(irq_n),
    .rst_req(rst_req_n)
  );

  always @(posedge clk) if (rst_n && rst_req) rst_cycles = rst_cycles + 1;

  // {timeout value, tick count, expected irq}
  localparam logic [39:0] VECS [8] = '{
    {24'd0,  8'd0,  8'd0}, {24'd0,  8'd1,  8'd1},
    {24'd3,  8'd3,  8'd0}, {24'd3,  8'd4,  8'd1},
    {24'd10, 8'd10, 8'd0}, {24'd10, 8'd11, 8'd1},
    {24'd1,  8'd1,  8'd0}, {24'd1,  8'd2,  8'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_us = 1'b1;
      @(negedge clk);
      tick_us = 1'b0;
    end
  endtask

  task automatic prep(input logic [W-1:0] v);
    wr(2'd1, '0);
    wr(2'd0, v);
    wr(2'd1, 1);
    rst_cycles = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", irq, 0);
    chk("R1 rst_req after reset", rst_req, 0);
    ticks(3);
    chk("R1/R7 disabled at reset ignores ticks", irq, 0);

    // R3 table walk
    for (int k = 0; k < 8; k++) begin
      prep(VECS[k][39:16]);
      ticks(int'(VECS[k][15:8]));
      chk($sformatf("R3 vector %0d irq", k), irq, VECS[k][7:0]);
    end

    // R4 first expiry reloads, R5 second expiry resets
    prep(2);
    ticks(3);
    chk("R4 irq on first expiry", irq, 1);
    chk("R4 no reset on first expiry", rst_cycles, 0);
    ticks(2);
    chk("R4 counter reloaded, no early reset", rst_cycles, 0);
    ticks(1);
    repeat (3) @(negedge clk);
    chk("R5 reset pulse is one cycle", rst_cycles, 1);
    chk("R5 irq still high after reset", irq, 1);

    // R6 kick clears
    prep(2);
    ticks(3);
    wr(2'd2, 0);
    chk("R6 kick clears irq", irq, 0);
    ticks(3);
    chk("R6 after kick next expiry is first again", irq, 1);
    chk("R6 no reset after kick", rst_cycles, 0);

    // R6 kick beats same-cycle expiry
    prep(1);
    ticks(1);
    tick_us = 1'b1;
    wr(2'd2, 0);
    tick_us = 1'b0;
    ticks(1);
    chk("R6 tick with kick ignored", irq, 0);
    ticks(1);
    chk("R6 expiry after kick reload", irq, 1);

    // R7 disable clears and holds
    prep(2);
    ticks(3);
    wr(2'd1, 0);
    chk("R7 disable clears irq", irq, 0);
    ticks(10);
    chk("R7 no irq while disabled", irq, 0);
    chk("R7 no reset while disabled", rst_cycles, 0);
    wr(2'd1, 1);
    ticks(3);
    chk("R7 flag cleared, expiry is first again", irq, 1);
    chk("R7 no reset after re-enable", rst_cycles, 0);

    prep(5);
    ticks(3);
    wr(2'd1, 0);
    ticks(5);
    wr(2'd1, 1);
    ticks(2);
    chk("R7 counter held while disabled", irq, 0);
    ticks(1);
    chk("R7 resumes from held count", irq, 1);

    // R2 idle cycles do not count
    prep(2);
    ticks(2);
    repeat (20) @(negedge clk);
    chk("R2 no expiry without tick", irq, 0);
    ticks(1);
    chk("R2 expiry on tick after idle", irq, 1);

    // R8 load reloads immediately
    prep(20);
    ticks(5);
    wr(2'd0, 1);
    ticks(1);
    chk("R8 new value loaded", irq, 0);
    ticks(1);
    chk("R8 expiry from new value", irq, 1);

    // R9 all-ones period on narrow instance
    prep({W{1'b0}} | 24'hFF);
    ticks(255);
    chk("R9 no expiry at 2^W-1 ticks", irq_n, 0);
    ticks(1);
    chk("R9 expiry at 2^W ticks", irq_n, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule